// File: doc/BRIEF.md
# Banked Data Fault Status Register

This block keeps the 32-bit data fault status word of a processor core in two banked copies, one for the Secure world and one for the Non-secure world. Hardware fills a copy when a data abort is taken. The abort descriptor is packed into one of two layouts: a short layout with a 5-bit fault code and a domain field, or a long layout with a 6-bit status code. A select input chooses the layout for each abort. Several fields are cleared when the kind of abort makes them meaningless.

Software reaches the register through system-register reads and writes, which are checked combinationally in the cycle they are presented. The check uses the current exception level, the security flag and the hypervisor trap controls. An access is reported undefined, reported as trapped to the hypervisor with a fixed syndrome, or performed on the copy that the privilege level and security flag select. Read data appears in the same cycle. A write takes effect at the next clock edge.

Top module: `fsr_bank_unit`

## Requirements
- R1: After reset both copies read as 0x00000000.
- R2: Short layout (`abt_long`=0): code bit 4 goes to bit 10, code bits 3:0 go to bits 3:0, the domain goes to bits 7:4, and bits 9 and 8 are 0.
- R3: Long layout (`abt_long`=1): the 6-bit status goes to bits 5:0, bit 9 is 1, and bits 10 and 8:6 are 0.
- R4: Bit 16 copies `abt_fnv` only for a synchronous external abort that is not on a table walk. For every other abort it is 0.
- R5: Bits 15:14 copy `abt_aet` for an asynchronous abort (00 uncontainable, 01 unrecoverable, 10 restartable/corrected, 11 recoverable). For a synchronous abort they are 0.
- R6: Bit 12 copies `abt_ext_type` only when `abt_ext`=1, and is 0 otherwise. Bit 13 copies `abt_cm`.
- R7: Bit 11 is 1 when `abt_cm_at`=1, and equals `abt_write` otherwise.
- R8: Any access at level 0 (`el`=0) raises `acc_undef` and returns zero read data. A write at level 0 changes neither copy.
- R9: At level 1 with `hyp_en`=1, `trap_all` traps reads and writes, `trap_vm_rd` traps only reads, and `trap_vm_wr` traps only writes. A trap raises `acc_trap` with `trap_syn`=0x03, returns zero read data and writes nothing.
- R10: The checks run in a fixed order: undefined, then `trap_all`, then the read/write trap, then the access itself. The trap controls have no effect at levels 2 and 3, or when `hyp_en`=0.
- R11: Copy selection follows the level and the monitor flag. At levels 1 and 3 with `mon32`=1, `ns`=1 selects the Non-secure copy and `ns`=0 selects the Secure copy. Level 2 always uses the Non-secure copy, and so does level 1 with `mon32`=0.
- R12: Bits 31:17 always read 0. Software writes to those bits are dropped.
- R13: If an abort capture and a software write target the same copy in the same cycle, the copy takes the abort value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| el | input | 2 | Current exception level (0..3) |
| ns | input | 1 | Security flag: 1 = Non-secure |
| hyp_en | input | 1 | Hypervisor level enabled |
| mon32 | input | 1 | A 32-bit monitor level is present |
| trap_all | input | 1 | Hypervisor trap bit 5: traps reads and writes |
| trap_vm_rd | input | 1 | Virtual-memory read trap |
| trap_vm_wr | input | 1 | Virtual-memory write trap |
| acc_valid | input | 1 | Software access present this cycle |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_wdata | input | 32 | Software write data |
| rd_data | output | 32 | Read data (zero unless a read is performed) |
| acc_undef | output | 1 | Access is undefined |
| acc_trap | output | 1 | Access traps to the hypervisor |
| trap_syn | output | 6 | Trap syndrome code (0x03 when trapping) |
| abt_valid | input | 1 | Capture an abort this cycle |
| abt_ns | input | 1 | Target copy of the capture: 1 = Non-secure |
| abt_long | input | 1 | Layout select: 1 = long |
| abt_status | input | 6 | Fault code (short layout uses bits 4:0) |
| abt_domain | input | 4 | Domain of the faulting address |
| abt_sync | input | 1 | Abort is synchronous |
| abt_ext | input | 1 | Abort is an external abort |
| abt_walk | input | 1 | Abort occurred on a table walk |
| abt_fnv | input | 1 | Fault address not valid |
| abt_aet | input | 2 | Asynchronous error type |
| abt_cm | input | 1 | Caused by cache maintenance |
| abt_ext_type | input | 1 | External abort classification |
| abt_write | input | 1 | Faulting access was a write |
| abt_cm_at | input | 1 | Caused by a cache maintenance or address translation instruction |

## Verification
The encoder is driven with descriptors in both layouts: a level-1 translation fault, an alignment fault from an address-translation instruction, a synchronous external abort both off and on a table walk, an asynchronous error, and a short code with bit 4 set. Each descriptor sets the fields that should be cleared, so a missing clear shows up as a stray bit at a known position. Accesses sweep the levels, the security flag, the monitor flag and each trap control one at a time. This separates an error in undefined/trap priority from an error in copy selection. A same-cycle capture and write shows which path wins.

// File: rtl/fsr_pkg.sv
// Shared constants and types for the banked fault status register unit.
package fsr_pkg;
    localparam int REG_W      = 32;   // register width
    localparam int LIVE_W     = 17;   // bits 16:0 are implemented, above read zero
    localparam int STAT_W     = 6;    // widest fault code (long layout)
    localparam int DOM_W      = 4;    // domain field width
    localparam int SYN_W      = 6;    // trap syndrome width
    localparam logic [SYN_W-1:0] TRAP_SYN = 6'h03;

    typedef enum logic [1:0] {
        LVL_USER = 2'd0,
        LVL_OS   = 2'd1,
        LVL_HYP  = 2'd2,
        LVL_MON  = 2'd3
    } lvl_e;

    // Abort descriptor delivered by the memory pipeline.
    typedef struct packed {
        logic              long_fmt;
        logic [STAT_W-1:0] status;
        logic [DOM_W-1:0]  domain;
        logic              sync;
        logic              ext;
        logic              walk;
        logic              fnv;
        logic [1:0]        aet;
        logic              cm;
        logic              ext_type;
        logic              write;
        logic              cm_at;
    } abort_t;
endpackage

// File: rtl/fsr_fault_encoder.sv
// Packs an abort descriptor into the status word in the layout selected per abort.
// Assumes REG_W >= 17; field positions are fixed by the register layout.
module fsr_fault_encoder
    import fsr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  abort_t       abt,
    output logic [W-1:0] word
);
    localparam int PAD_W = W - LIVE_W;

    logic       fnv_q;
    logic [1:0] aet_q;
    logic       ext_t_q;
    logic       wnr_q;
    logic [10:0] fmt_low;   // bits 10:0

    // Clear fields that do not apply to this kind of abort.
    always_comb begin
        fnv_q   = abt.fnv & abt.sync & abt.ext & ~abt.walk;
        aet_q   = abt.sync ? 2'b00 : abt.aet;
        ext_t_q = abt.ext & abt.ext_type;
        wnr_q   = abt.cm_at | abt.write;
    end

    // Layout-specific low bits: long keeps a 6-bit code, short splits a 5-bit one.
    always_comb begin
        if (abt.long_fmt)
            fmt_low = {1'b0, 1'b1, 3'b000, abt.status};
        else
            fmt_low = {abt.status[4], 1'b0, 1'b0, abt.domain, abt.status[3:0]};
    end

    // Assemble the full word with the unimplemented top bits tied to zero.
    always_comb begin
        word = {{PAD_W{1'b0}}, fnv_q, aet_q, abt.cm, ext_t_q, wnr_q, fmt_low};
    end
endmodule

// File: rtl/fsr_access_ctrl.sv
// Decides the outcome of a software access: undefined, trapped, or performed,
// and which banked copy it addresses. Purely combinational.
// Assumes only one access per cycle; level encoding follows fsr_pkg::lvl_e.
module fsr_access_ctrl
    import fsr_pkg::*;
#(
    parameter int SW = SYN_W
) (
    input  logic          acc_valid,
    input  logic          acc_write,
    input  lvl_e          lvl,
    input  logic          ns,
    input  logic          hyp_en,
    input  logic          mon32,
    input  logic          trap_all,
    input  logic          trap_vm_rd,
    input  logic          trap_vm_wr,
    output logic          undef,
    output logic          trap,
    output logic [SW-1:0] syn,
    output logic          perform,
    output logic          bank_ns
);
    logic os_gate;

    // Trap controls only matter at the OS level with the hypervisor enabled.
    always_comb os_gate = (lvl == LVL_OS) && hyp_en;

    // Priority chain: undefined, trap-all, per-direction trap, then perform.
    always_comb begin
        undef   = 1'b0;
        trap    = 1'b0;
        perform = 1'b0;
        if (acc_valid) begin
            if (lvl == LVL_USER)
                undef = 1'b1;
            else if (os_gate && trap_all)
                trap = 1'b1;
            else if (os_gate && !acc_write && trap_vm_rd)
                trap = 1'b1;
            else if (os_gate && acc_write && trap_vm_wr)
                trap = 1'b1;
            else
                perform = 1'b1;
        end
        syn = trap ? SW'(TRAP_SYN) : '0;
    end

    // Copy selection from level, monitor presence and the security flag.
    always_comb begin
        unique case (lvl)
            LVL_OS:  bank_ns = mon32 ? ns : 1'b1;
            LVL_MON: bank_ns = ns;
            default: bank_ns = 1'b1;
        endcase
    end
endmodule

// File: rtl/fsr_bank_store.sv
// Holds the banked copies. Per copy, an abort capture outranks a software write.
// Assumes synchronous active-low reset; software data is masked to LIVE bits.
module fsr_bank_store #(
    parameter int W      = 32,
    parameter int LIVE   = 17,
    parameter int BANKS  = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         hw_we,
    input  logic [BW-1:0]                hw_bank,
    input  logic [W-1:0]                 hw_data,
    input  logic                         sw_we,
    input  logic [BW-1:0]                sw_bank,
    input  logic [W-1:0]                 sw_data,
    output logic [BANKS-1:0][W-1:0]      q
);
    localparam int BW = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam logic [W-1:0] LIVE_MASK = W'((64'd1 << LIVE) - 64'd1);

    for (genvar b = 0; b < BANKS; b++) begin : g_bank
        localparam logic [BW-1:0] IDX = BW'(b);
        logic hit_hw, hit_sw;

        // Decode which write paths target this copy.
        always_comb begin
            hit_hw = hw_we && (hw_bank == IDX);
            hit_sw = sw_we && (sw_bank == IDX);
        end

        // Register update with hardware capture taking precedence.
        always_ff @(posedge clk) begin
            if (!rst_n)
                q[b] <= '0;
            else if (hit_hw)
                q[b] <= hw_data & LIVE_MASK;
            else if (hit_sw)
                q[b] <= sw_data & LIVE_MASK;
        end
    end
endmodule

// File: rtl/fsr_bank_unit.sv
// Top of the banked fault status register unit: abort encoding, software
// access control and the two banked copies (index 1 = Non-secure).
// Assumes one software access and at most one abort capture per cycle.
module fsr_bank_unit
    import fsr_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        el,
    input  logic              ns,
    input  logic              hyp_en,
    input  logic              mon32,
    input  logic              trap_all,
    input  logic              trap_vm_rd,
    input  logic              trap_vm_wr,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic [W-1:0]      acc_wdata,
    output logic [W-1:0]      rd_data,
    output logic              acc_undef,
    output logic              acc_trap,
    output logic [SYN_W-1:0]  trap_syn,
    input  logic              abt_valid,
    input  logic              abt_ns,
    input  logic              abt_long,
    input  logic [STAT_W-1:0] abt_status,
    input  logic [DOM_W-1:0]  abt_domain,
    input  logic              abt_sync,
    input  logic              abt_ext,
    input  logic              abt_walk,
    input  logic              abt_fnv,
    input  logic [1:0]        abt_aet,
    input  logic              abt_cm,
    input  logic              abt_ext_type,
    input  logic              abt_write,
    input  logic              abt_cm_at
);
    localparam int BANKS = 2;

    abort_t              abt;
    logic [W-1:0]        enc_word;
    logic                perform, bank_ns;
    logic [BANKS-1:0][W-1:0] bank_q;

    // Gather the abort inputs into one descriptor.
    always_comb begin
        abt = '{long_fmt: abt_long, status: abt_status, domain: abt_domain,
                sync: abt_sync, ext: abt_ext, walk: abt_walk, fnv: abt_fnv,
                aet: abt_aet, cm: abt_cm, ext_type: abt_ext_type,
                write: abt_write, cm_at: abt_cm_at};
    end

    fsr_fault_encoder #(.W(W)) u_enc (
        .abt  (abt),
        .word (enc_word)
    );

    fsr_access_ctrl #(.SW(SYN_W)) u_ctrl (
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .lvl        (lvl_e'(el)),
        .ns         (ns),
        .hyp_en     (hyp_en),
        .mon32      (mon32),
        .trap_all   (trap_all),
        .trap_vm_rd (trap_vm_rd),
        .trap_vm_wr (trap_vm_wr),
        .undef      (acc_undef),
        .trap       (acc_trap),
        .syn        (trap_syn),
        .perform    (perform),
        .bank_ns    (bank_ns)
    );

    fsr_bank_store #(.W(W), .LIVE(LIVE_W), .BANKS(BANKS)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .hw_we   (abt_valid),
        .hw_bank (abt_ns),
        .hw_data (enc_word),
        .sw_we   (perform && acc_write),
        .sw_bank (bank_ns),
        .sw_data (acc_wdata),
        .q       (bank_q)
    );

    // Read data only for a performed read; zero otherwise.
    always_comb rd_data = (perform && !acc_write) ? bank_q[bank_ns] : '0;
endmodule

// File: rtl/fsr_bank_unit_chk.sv
// Property checker for fsr_bank_unit, attached through bind.
module fsr_bank_unit_chk (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       el,
    input logic             acc_valid,
    input logic             acc_write,
    input logic [31:0]      rd_data,
    input logic             acc_undef,
    input logic             acc_trap,
    input logic [5:0]       trap_syn,
    input logic             abt_valid,
    input logic             abt_ns,
    input logic             abt_long,
    input logic             abt_sync,
    input logic [1:0][31:0] bank_q
);
    // R8
    el0_undef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && el == 2'd0) |-> (acc_undef && !acc_trap && rd_data == 32'd0));

    // R8
    el0_write_inert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_write && el == 2'd0 && !abt_valid) |=> $stable(bank_q));

    // R9
    trap_syndrome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc_trap |-> (trap_syn == 6'h03 && rd_data == 32'd0));

    // R10
    undef_trap_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(acc_undef && acc_trap));

    // R12
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_q[0][31:17] == 15'd0) && (bank_q[1][31:17] == 15'd0));

    // R3
    long_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_valid && abt_long) |=>
        (($past(abt_ns) ? bank_q[1][10:6] : bank_q[0][10:6]) == 5'b01000));

    // R2
    short_marker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_valid && !abt_long) |=>
        (($past(abt_ns) ? bank_q[1][9:8] : bank_q[0][9:8]) == 2'b00));

    // R5
    sync_aet_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abt_valid && abt_sync) |=>
        (($past(abt_ns) ? bank_q[1][15:14] : bank_q[0][15:14]) == 2'b00));
endmodule

bind fsr_bank_unit fsr_bank_unit_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .el        (el),
    .acc_valid (acc_valid),
    .acc_write (acc_write),
    .rd_data   (rd_data),
    .acc_undef (acc_undef),
    .acc_trap  (acc_trap),
    .trap_syn  (trap_syn),
    .abt_valid (abt_valid),
    .abt_ns    (abt_ns),
    .abt_long  (abt_long),
    .abt_sync  (abt_sync),
    .bank_q    (bank_q)
);

// File: tb/tb_fsr_bank_unit.sv
// Scoreboard bench: the driver queues expected access results, the monitor
// pops and compares them at the falling edge while an access is presented.
module tb_fsr_bank_unit;
    import fsr_pkg::*;

    typedef struct {
        logic [31:0] rd;
        logic        undef;
        logic        trap;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  el = 2'd3;
    logic        ns = 1'b0, hyp_en = 1'b1, mon32 = 1'b1;
    logic        trap_all = 1'b0, trap_vm_rd = 1'b0, trap_vm_wr = 1'b0;
    logic        acc_valid = 1'b0, acc_write = 1'b0;
    logic [31:0] acc_wdata = '0;
    logic [31:0] rd_data;
    logic        acc_undef, acc_trap;
    logic [5:0]  trap_syn;
    logic        abt_valid = 1'b0, abt_ns = 1'b0;
    abort_t      abt = '0;

    exp_t exp_q[$];
    int   n_chk = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #5 clk = ~clk;

    fsr_bank_unit dut (
        .clk(clk), .rst_n(rst_n), .el(el), .ns(ns), .hyp_en(hyp_en), .mon32(mon32),
        .trap_all(trap_all), .trap_vm_rd(trap_vm_rd), .trap_vm_wr(trap_vm_wr),
        .acc_valid(acc_valid), .acc_write(acc_write), .acc_wdata(acc_wdata),
        .rd_data(rd_data), .acc_undef(acc_undef), .acc_trap(acc_trap), .trap_syn(trap_syn),
        .abt_valid(abt_valid), .abt_ns(abt_ns), .abt_long(abt.long_fmt),
        .abt_status(abt.status), .abt_domain(abt.domain), .abt_sync(abt.sync),
        .abt_ext(abt.ext), .abt_walk(abt.walk), .abt_fnv(abt.fnv), .abt_aet(abt.aet),
        .abt_cm(abt.cm), .abt_ext_type(abt.ext_type), .abt_write(abt.write),
        .abt_cm_at(abt.cm_at)
    );

    function automatic abort_t mk(logic lf, logic [5:0] st, logic [3:0] dom, logic sy,
                                  logic ex, logic wk, logic fv, logic [1:0] ae, logic c,
                                  logic et, logic wr, logic ca);
        abort_t a;
        a = '{long_fmt: lf, status: st, domain: dom, sync: sy, ext: ex, walk: wk,
              fnv: fv, aet: ae, cm: c, ext_type: et, write: wr, cm_at: ca};
        return a;
    endfunction

    // Drive one software access, optionally with a same-cycle abort capture.
    task automatic access(input logic [1:0] e, input logic n, input logic w,
                          input logic [31:0] wd, input logic hw,
                          input logic [31:0] xr, input logic xu, input logic xt,
                          input string tag);
        exp_t it;
        @(posedge clk); #1;
        el = e; ns = n; acc_write = w; acc_wdata = wd; acc_valid = 1'b1;
        abt_valid = hw;
        it.rd = xr; it.undef = xu; it.trap = xt; it.tag = tag;
        exp_q.push_back(it);
        @(posedge clk); #1;
        acc_valid = 1'b0; abt_valid = 1'b0;
    endtask

    // Present one abort capture for a single cycle.
    task automatic capture(input logic n, input abort_t a);
        @(posedge clk); #1;
        abt = a; abt_ns = n; abt_valid = 1'b1;
        @(posedge clk); #1;
        abt_valid = 1'b0;
    endtask

    task automatic rd(input logic [1:0] e, input logic n, input logic [31:0] xr, input string tag);
        access(e, n, 1'b0, 32'd0, 1'b0, xr, 1'b0, 1'b0, tag);
    endtask

    // Monitor: compare every presented access against the queued expectation.
    always @(negedge clk) begin
        if (acc_valid && !done) begin
            n_chk++;
            if (exp_q.size() == 0) begin
                n_fail++;
                $display("FAIL scoreboard empty: rd=%h undef=%b trap=%b expected nothing",
                         rd_data, acc_undef, acc_trap);
            end else begin
                exp_t it;
                logic [5:0] xs;
                it = exp_q.pop_front();
                xs = it.trap ? 6'h03 : 6'h00;
                if (rd_data !== it.rd || acc_undef !== it.undef || acc_trap !== it.trap
                    || trap_syn !== xs) begin
                    n_fail++;
                    $display("FAIL %s: rd=%h undef=%b trap=%b syn=%h expected rd=%h undef=%b trap=%b syn=%h",
                             it.tag, rd_data, acc_undef, acc_trap, trap_syn,
                             it.rd, it.undef, it.trap, xs);
                end
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 both copies clear after reset
        rd(2'd3, 1'b0, 32'h0, "R1 secure copy after reset");
        rd(2'd3, 1'b1, 32'h0, "R1 non-secure copy after reset");

        // R2 R4 R5 R6: short translation fault, stray fnv/aet/ext_type cleared
        capture(1'b1, mk(1'b0, 6'b000101, 4'hA, 1'b1, 1'b0, 1'b0, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1, 1'b0));
        rd(2'd3, 1'b1, 32'h0000_08A5, "R2 R4 R5 R6 short translation L1");
        rd(2'd3, 1'b0, 32'h0, "R11 secure copy untouched by NS capture");

        // R3 R7: long alignment fault from address translation instruction
        capture(1'b0, mk(1'b1, 6'b100001, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1));
        rd(2'd3, 1'b0, 32'h0000_0A21, "R3 R7 long alignment, wnr forced");

        // R4 R6: synchronous external abort off a walk keeps fnv and ext type
        capture(1'b0, mk(1'b0, 6'b001000, 4'h3, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0));
        rd(2'd3, 1'b0, 32'h0001_3038, "R4 R6 sync external not on walk");

        // R4: on a walk fnv is cleared
        capture(1'b0, mk(1'b0, 6'b001100, 4'h3, 1'b1, 1'b1, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 1'b0, 1'b0));
        rd(2'd3, 1'b0, 32'h0000_303C, "R4 sync external on walk");

        // R5 R3: asynchronous long error keeps aet, fnv cleared
        capture(1'b1, mk(1'b1, 6'b010001, 4'h0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b10, 1'b0, 1'b0, 1'b0, 1'b0));
        rd(2'd3, 1'b1, 32'h0000_8211, "R5 R3 async long error type");

        // R2 R6: short code with bit 4 set, non-external ext type cleared
        capture(1'b1, mk(1'b0, 6'b010110, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0));
        rd(2'd3, 1'b1, 32'h0000_4406, "R2 R6 short code bit4 split");

        // R12 R11: write all ones through level 1 secure, upper bits dropped
        access(2'd1, 1'b0, 1'b1, 32'hFFFF_FFFF, 1'b0, 32'h0, 1'b0, 1'b0, "R12 write all ones");
        rd(2'd1, 1'b0, 32'h0001_FFFF, "R12 R11 upper bits read zero");

        // R8 level 0 undefined for read and write
        access(2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, "R8 level0 read");
        access(2'd0, 1'b0, 1'b1, 32'h0000_1234, 1'b0, 32'h0, 1'b1, 1'b0, "R8 level0 write");
        rd(2'd3, 1'b0, 32'h0001_FFFF, "R8 level0 write had no effect");

        // R9 read trap only
        trap_vm_rd = 1'b1;
        access(2'd1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, "R9 read trap on read");
        access(2'd1, 1'b0, 1'b1, 32'h0000_0123, 1'b0, 32'h0, 1'b0, 1'b0, "R9 read trap passes write");
        trap_vm_rd = 1'b0;
        rd(2'd1, 1'b0, 32'h0000_0123, "R9 write under read trap landed");

        // R9 write trap only
        trap_vm_wr = 1'b1;
        access(2'd1, 1'b0, 1'b1, 32'h0000_0456, 1'b0, 32'h0, 1'b0, 1'b1, "R9 write trap on write");
        rd(2'd1, 1'b0, 32'h0000_0123, "R9 write trap passes read, value kept");
        trap_vm_wr = 1'b0;

        // R9 R10 trap-all
        trap_all = 1'b1;
        access(2'd1, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b0, 1'b1, "R9 trap_all read");
        access(2'd1, 1'b0, 1'b1, 32'h0000_0789, 1'b0, 32'h0, 1'b0, 1'b1, "R9 trap_all write");
        access(2'd0, 1'b0, 1'b0, 32'h0, 1'b0, 32'h0, 1'b1, 1'b0, "R10 undefined outranks trap");
        rd(2'd2, 1'b0, 32'h0000_4406, "R10 R11 level2 not trapped, uses NS copy");
        hyp_en = 1'b0;
        rd(2'd1, 1'b0, 32'h0000_0123, "R10 R9 no trap with hypervisor off, write was dropped");
        hyp_en = 1'b1;
        trap_all = 1'b0;

        // R11 without a 32-bit monitor level 1 uses the NS copy
        mon32 = 1'b0;
        rd(2'd1, 1'b0, 32'h0000_4406, "R11 no monitor selects NS copy");
        mon32 = 1'b1;
        access(2'd3, 1'b1, 1'b1, 32'h0000_0ABC, 1'b0, 32'h0, 1'b0, 1'b0, "R11 monitor NS write");
        rd(2'd1, 1'b1, 32'h0000_0ABC, "R11 level1 ns=1 reads NS copy");

        // R13 same-cycle capture and write to the NS copy
        abt = mk(1'b0, 6'b000001, 4'h0, 1'b1, 1'b0, 1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b0);
        abt_ns = 1'b1;
        access(2'd3, 1'b1, 1'b1, 32'h0000_AAAA, 1'b1, 32'h0, 1'b0, 1'b0, "R13 collision write");
        rd(2'd3, 1'b1, 32'h0000_0001, "R13 capture wins over write");

        repeat (2) @(posedge clk);
        if (exp_q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL scoreboard: %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule